// File: doc/BRIEF.md
# Serial Flash Command Controller

A host CPU drives this block through an 8-bit register window and sees a serial flash on a four-wire SPI link. The host loads the flash address bytes and, when the command needs one, an outgoing data byte. It then writes an opcode to the command register, and that write alone starts the transaction. The controller decodes the opcode to choose the shape of the frame: an opcode only, an opcode with a 24-bit address, dummy bytes, a single written byte, a single read byte, or an open-ended stream.

Streams run in both directions. A page program frame raises a write-data request and waits for the host each time it can take another byte. A continuous read frame keeps clocking bytes in, and after each one it raises receive-ready and holds the byte for the host. A streamed frame keeps chip select asserted until the host writes the no-op opcode 0xFF. Progress is visible in a status register. SCLK runs at the system clock divided by `SCLK_DIV`, which defaults to 4.

Top module: `spi_flash_ctrl`

## Requirements
- R1: Host addresses: 0 = data (a write stores the outgoing byte, a read returns the last received byte), 1 = command on write and status on read, 2/3/4 = flash address bits 7:0, 15:8 and 23:16, readable back. A write takes effect in the cycle where sel_i and wr_i are both high. A read of the data register is counted in the cycle where sel_i and rd_i are both high.
- R2: Status bits: bit0 busy, bit1 shifter idle (transmit empty), bit2 receive-ready, bit3 write-data request, bits 7:4 zero. After reset the status reads 0x02, cs_no is 1 and sclk_o is 0.
- R3: Every byte goes out MSB first in SPI mode 0. MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and SCLK stays low while chip select is inactive. Inside a byte the SCLK period is `SCLK_DIV` clocks.
- R4: Opcodes 0x06, 0x04, 0xC7, 0xB9 and any opcode not listed elsewhere produce a frame of exactly one byte.
- R5: Opcode 0x01 produces a frame of the opcode followed by the byte last written to the data register.
- R6: Opcode 0xD8 produces a frame of the opcode followed by the address, high byte first.
- R7: Opcode 0x02 sends the opcode and the address, high byte first, then sets the write-data request. A host data write clears the request and sends that byte, and the request rises again once the byte is out. Chip select stays low until 0xFF is written.
- R8: Opcode 0x03 sends the opcode and the address, then clocks in bytes back to back with MOSI at 0x00. Each byte sets receive-ready and is held in the data register. After 0xFF is written, the byte in flight completes and chip select is released.
- R9: Opcode 0x0B behaves as R8, but one 0x00 dummy byte follows the address before the data bytes.
- R10: Opcode 0x05 sends the opcode and then one 0x00 byte whose received value becomes the data register, with receive-ready set. Opcode 0xAB does the same after three 0x00 dummy bytes.
- R11: Reading the data register clears receive-ready. Busy is set from the command write until chip select is released. Chip select falls only in the cycle after a command write.
- R12: A command write other than 0xFF while busy is ignored. A 0xFF write while idle starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Host register select |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 3 | Host register address |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data, combinational on addr_i |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The assertions check the link discipline on every cycle. SCLK stays low with chip select high, MOSI holds while SCLK is high, and an SCLK high phase lasts more than one cycle. Chip select may fall only after a command write. Receive-ready clears on a data-register read, and the write-data request clears on a data write. Frame contents, byte counts, dummy insertion, the end of a stream on 0xFF, and ignored commands show up only in the bench scenarios. There, a serial slave model compares every MOSI byte and every frame length against a scoreboard and returns known MISO bytes.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;
  localparam logic [7:0] OP_NOOP = 8'hFF;

  typedef enum logic [2:0] {DM_NONE, DM_WR1, DM_RD1, DM_RDS, DM_WRS} data_mode_e;

  typedef struct packed {
    logic       has_addr;
    logic [1:0] n_dummy;
    data_mode_e mode;
  } frame_cfg_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_OPC, PH_ADR, PH_DUM, PH_WD, PH_RX1, PH_RXS, PH_WS, PH_WAITW
  } phase_e;

  function automatic frame_cfg_t decode_op(input logic [7:0] op);
    frame_cfg_t c;
    c = '{has_addr: 1'b0, n_dummy: 2'd0, mode: DM_NONE};
    unique case (op)
      8'h01: c.mode = DM_WR1;
      8'h05: c.mode = DM_RD1;
      8'hAB: begin c.n_dummy = 2'd3; c.mode = DM_RD1; end
      8'h03: begin c.has_addr = 1'b1; c.mode = DM_RDS; end
      8'h0B: begin c.has_addr = 1'b1; c.n_dummy = 2'd1; c.mode = DM_RDS; end
      8'h02: begin c.has_addr = 1'b1; c.mode = DM_WRS; end
      8'hD8: c.has_addr = 1'b1;
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/spi_fc_clkdiv.sv
module spi_fc_clkdiv #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_fc_shifter.sv
module spi_fc_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       active_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic       active_q, sclk_q, done_q, tick;
  logic [2:0] bit_q;
  logic [7:0] sh_q, rx_q;

  spi_fc_clkdiv #(.HALF_CYC(HALF_CYC)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        bit_q    <= '0;
        sh_q     <= tx_i;
      end else if (active_q && tick) begin
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = sh_q[7];
endmodule

// File: rtl/spi_fc_regs.sv
module spi_fc_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  data_i,
  output logic [7:0]  data_o,
  input  logic [7:0]  stat_i,
  input  logic        rx_cap_i,
  input  logic [7:0]  rx_byte_i,
  output logic        cmd_we_o,
  output logic        dat_we_o,
  output logic [7:0]  tx_hold_o,
  output logic [23:0] faddr_o,
  output logic        rxr_o
);
  logic [7:0] tx_q, rx_q, a_lo_q, a_mid_q, a_hi_q;
  logic       rxr_q, wr_en, rd_clr;

  assign wr_en    = sel_i && wr_i;
  assign cmd_we_o = wr_en && (addr_i == 3'd1);
  assign dat_we_o = wr_en && (addr_i == 3'd0);
  assign rd_clr   = sel_i && rd_i && (addr_i == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0; rx_q <= '0; a_lo_q <= '0; a_mid_q <= '0; a_hi_q <= '0;
      rxr_q <= 1'b0;
    end else begin
      if (dat_we_o)                      tx_q    <= data_i;
      if (wr_en && addr_i == 3'd2)       a_lo_q  <= data_i;
      if (wr_en && addr_i == 3'd3)       a_mid_q <= data_i;
      if (wr_en && addr_i == 3'd4)       a_hi_q  <= data_i;
      if (rx_cap_i) begin
        rx_q  <= rx_byte_i;
        rxr_q <= 1'b1;
      end else if (rd_clr) begin
        rxr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      3'd0:    data_o = rx_q;
      3'd1:    data_o = stat_i;
      3'd2:    data_o = a_lo_q;
      3'd3:    data_o = a_mid_q;
      3'd4:    data_o = a_hi_q;
      default: data_o = 8'h00;
    endcase
  end

  assign tx_hold_o = tx_q;
  assign faddr_o   = {a_hi_q, a_mid_q, a_lo_q};
  assign rxr_o     = rxr_q;
endmodule

// File: rtl/spi_fc_seq.sv
module spi_fc_seq
  import spi_fc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic        dat_we_i,
  input  logic [7:0]  data_i,
  input  logic [7:0]  tx_hold_i,
  input  logic [23:0] faddr_i,
  input  logic        done_i,
  output logic        start_o,
  output logic [7:0]  tx_o,
  output logic        cs_no,
  output logic        busy_o,
  output logic        wreq_o,
  output logic        rx_cap_o
);
  phase_e     ph_q, ph_d;
  frame_cfg_t cfg_q, cfg_d;
  logic [1:0] cnt_q, cnt_d;
  logic [7:0] tx_q, tx_d;
  logic       go, fin, stop_q, wreq_q, wreq_set, wreq_clr, cs_q;
  logic       en_adr, en_dum, en_dat;

  always_comb begin
    ph_d = ph_q; cfg_d = cfg_q; cnt_d = cnt_q; tx_d = tx_q;
    go = 1'b0; fin = 1'b0; wreq_set = 1'b0; wreq_clr = 1'b0; rx_cap_o = 1'b0;
    en_adr = 1'b0; en_dum = 1'b0; en_dat = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (cmd_we_i && data_i != OP_NOOP) begin
        ph_d = PH_OPC; go = 1'b1; tx_d = data_i; cfg_d = decode_op(data_i);
      end
      PH_WAITW: begin
        if (stop_q) fin = 1'b1;
        else if (dat_we_i) begin
          ph_d = PH_WS; go = 1'b1; tx_d = data_i; wreq_clr = 1'b1;
        end
      end
      PH_OPC: if (done_i) begin
        en_adr = cfg_q.has_addr;
        en_dum = !cfg_q.has_addr && cfg_q.n_dummy != 2'd0;
        en_dat = !cfg_q.has_addr && cfg_q.n_dummy == 2'd0;
      end
      PH_ADR: if (done_i) begin
        if (cnt_q == 2'd2) begin
          en_dum = cfg_q.n_dummy != 2'd0;
          en_dat = cfg_q.n_dummy == 2'd0;
        end else begin
          cnt_d = cnt_q + 2'd1; go = 1'b1;
          tx_d  = (cnt_q == 2'd0) ? faddr_i[15:8] : faddr_i[7:0];
        end
      end
      PH_DUM: if (done_i) begin
        if (cnt_q == cfg_q.n_dummy - 2'd1) en_dat = 1'b1;
        else begin cnt_d = cnt_q + 2'd1; go = 1'b1; tx_d = 8'h00; end
      end
      PH_WD:  if (done_i) fin = 1'b1;
      PH_RX1: if (done_i) begin rx_cap_o = 1'b1; fin = 1'b1; end
      PH_RXS: if (done_i) begin
        rx_cap_o = 1'b1;
        if (stop_q) fin = 1'b1;
        else begin go = 1'b1; tx_d = 8'h00; end
      end
      PH_WS: if (done_i) begin
        if (stop_q) fin = 1'b1;
        else begin ph_d = PH_WAITW; wreq_set = 1'b1; end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (en_adr) begin ph_d = PH_ADR; cnt_d = 2'd0; go = 1'b1; tx_d = faddr_i[23:16]; end
    if (en_dum) begin ph_d = PH_DUM; cnt_d = 2'd0; go = 1'b1; tx_d = 8'h00; end
    if (en_dat) begin
      unique case (cfg_q.mode)
        DM_WR1: begin ph_d = PH_WD;  go = 1'b1; tx_d = tx_hold_i; end
        DM_RD1: begin ph_d = PH_RX1; go = 1'b1; tx_d = 8'h00; end
        DM_RDS: begin ph_d = PH_RXS; go = 1'b1; tx_d = 8'h00; end
        DM_WRS: begin ph_d = PH_WAITW; wreq_set = 1'b1; end
        default: fin = 1'b1;
      endcase
    end
    if (fin) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cfg_q   <= '{has_addr: 1'b0, n_dummy: 2'd0, mode: DM_NONE};
      cnt_q   <= '0;
      tx_q    <= '0;
      start_o <= 1'b0;
      stop_q  <= 1'b0;
      wreq_q  <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      ph_q    <= ph_d;
      cfg_q   <= cfg_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      start_o <= go;
      cs_q    <= (ph_d == PH_IDLE);
      if (ph_d == PH_IDLE) stop_q <= 1'b0;
      else if (cmd_we_i && data_i == OP_NOOP && ph_q != PH_IDLE) stop_q <= 1'b1;
      if (wreq_clr || ph_d == PH_IDLE) wreq_q <= 1'b0;
      else if (wreq_set)               wreq_q <= 1'b1;
    end
  end

  assign tx_o   = tx_q;
  assign cs_no  = cs_q;
  assign busy_o = (ph_q != PH_IDLE);
  assign wreq_o = wreq_q;
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl #(
  parameter int SCLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       sclk_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int HALF_CYC = (SCLK_DIV < 4) ? 2 : SCLK_DIV / 2;

  logic        cmd_we, dat_we, rx_cap, rxr, busy, wreq, start, active, done;
  logic [7:0]  tx_hold, tx_byte, rx_byte, stat;
  logic [23:0] faddr;

  assign stat = {4'b0000, wreq, rxr, !active, busy};

  spi_fc_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .data_o   (data_o),
    .stat_i   (stat),
    .rx_cap_i (rx_cap),
    .rx_byte_i(rx_byte),
    .cmd_we_o (cmd_we),
    .dat_we_o (dat_we),
    .tx_hold_o(tx_hold),
    .faddr_o  (faddr),
    .rxr_o    (rxr)
  );

  spi_fc_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (cmd_we),
    .dat_we_i (dat_we),
    .data_i   (data_i),
    .tx_hold_i(tx_hold),
    .faddr_i  (faddr),
    .done_i   (done),
    .start_o  (start),
    .tx_o     (tx_byte),
    .cs_no    (cs_no),
    .busy_o   (busy),
    .wreq_o   (wreq),
    .rx_cap_o (rx_cap)
  );

  spi_fc_shifter #(.HALF_CYC(HALF_CYC)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (tx_byte),
    .active_o(active),
    .done_o  (done),
    .rx_o    (rx_byte),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );
endmodule

// File: rtl/spi_fc_chk.sv
module spi_fc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [2:0] addr_i,
  input logic       sclk_o,
  input logic       cs_no,
  input logic       mosi_o,
  input logic [7:0] stat,
  input logic       rx_cap
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  // R3
  sclk_high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |=> sclk_o);

  // R11
  cs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(sel_i && wr_i && addr_i == 3'd1));

  // R11
  rxr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && addr_i == 3'd0 && !rx_cap) |=> !stat[2]);

  // R7
  wreq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == 3'd0 && stat[3]) |=> !stat[3]);

  // R2
  stat_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[7:4] == 4'h0);
endmodule

bind spi_flash_ctrl spi_fc_chk i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sel_i (sel_i),
  .wr_i  (wr_i),
  .rd_i  (rd_i),
  .addr_i(addr_i),
  .sclk_o(sclk_o),
  .cs_no (cs_no),
  .mosi_o(mosi_o),
  .stat  (stat),
  .rx_cap(rx_cap)
);

// File: tb/test_spi_flash_ctrl.sv
`timescale 1ns/1ps
module test_spi_flash_ctrl;
  localparam int SCLK_DIV = 4;
  localparam int WD_CYC   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic       sclk, cs_n, mosi, miso = 1'b1;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spi_flash_ctrl #(.SCLK_DIV(SCLK_DIV)) i_spi_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .data_i(din), .data_o(dout),
    .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'hC3 ^ 8'(k * 43);
  endfunction

  // scoreboard
  logic [7:0] exp_b_q[$];
  string      exp_br_q[$];
  int         exp_l_q[$];
  string      exp_lr_q[$];

  task automatic push_b(input string req, input logic [7:0] v);
    exp_b_q.push_back(v); exp_br_q.push_back(req);
  endtask
  task automatic push_len(input string req, input int n);
    exp_l_q.push_back(n); exp_lr_q.push_back(req);
  endtask

  // serial slave monitor
  bit         armed = 1'b0;
  int         mon_bits, frame_bytes, rsp_k, rsp_b;
  logic [7:0] mon_sh, rsp_sh;
  realtime    last_rise;

  always @(negedge cs_n) begin
    mon_bits = 0; frame_bytes = 0; rsp_k = 0; rsp_b = 0;
    rsp_sh = resp(0); miso = rsp_sh[7];
  end

  always @(negedge sclk) if (cs_n === 1'b0) begin
    rsp_b++;
    if (rsp_b == 8) begin rsp_b = 0; rsp_k++; rsp_sh = resp(rsp_k); end
    else rsp_sh = {rsp_sh[6:0], 1'b0};
    miso = rsp_sh[7];
  end

  always @(posedge sclk) if (cs_n === 1'b0) begin
    if (mon_bits != 0) chk("R3 sclk period", 32'($realtime - last_rise), 32'(SCLK_DIV * 4));
    last_rise = $realtime;
    mon_sh = {mon_sh[6:0], mosi};
    mon_bits++;
    if (mon_bits == 8) begin
      mon_bits = 0; frame_bytes++;
      if (exp_b_q.size() == 0) chk("R12 unexpected mosi byte", mon_sh, 32'hFFFF_FFFF);
      else chk(exp_br_q.pop_front(), mon_sh, exp_b_q.pop_front());
    end
  end

  always @(posedge cs_n) if (armed) begin
    chk("R3 whole bytes", mon_bits, 0);
    if (exp_l_q.size() == 0) chk("R12 unexpected frame", frame_bytes, 32'hFFFF_FFFF);
    else chk(exp_lr_q.pop_front(), frame_bytes, exp_l_q.pop_front());
  end

  // host bus driver
  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; din = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask
  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = dout;
    @(negedge clk); sel = 1'b0; rd = 1'b0;
  endtask
  task automatic wait_stat(input int bitpos, input logic val);
    logic [7:0] s;
    s = ~{8{val}};
    while (s[bitpos] !== val) bus_rd(3'd1, s);
  endtask
  task automatic set_addr(input logic [23:0] a);
    bus_wr(3'd2, a[7:0]); bus_wr(3'd3, a[15:8]); bus_wr(3'd4, a[23:16]);
  endtask
  task automatic stream_read(input string req, input logic [7:0] op, input bit fast, input int k);
    logic [7:0] v;
    int base;
    base = fast ? 5 : 4;
    set_addr(24'h56_34_12);
    push_len(req, base + k + 1);
    push_b(req, op); push_b(req, 8'h56); push_b(req, 8'h34); push_b(req, 8'h12);
    if (fast) push_b("R9 dummy", 8'h00);
    for (int j = 0; j < k; j++) push_b(req, 8'h00);
    bus_wr(3'd1, op);
    for (int j = 0; j < k; j++) begin
      wait_stat(2, 1'b1);
      bus_rd(3'd0, v);
      chk(req, v, resp(base + j));
    end
    push_b(req, 8'h00);
    bus_wr(3'd1, 8'hFF);
    wait_stat(0, 1'b0);
    bus_rd(3'd0, v);
    chk({req, " last byte held"}, v, resp(base + k));
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; armed = 1'b1;
    @(negedge clk);
    bus_rd(3'd1, v); chk("R2 reset status", v, 8'h02);
    chk("R2 reset cs", cs_n, 1'b1);
    chk("R2 reset sclk", sclk, 1'b0);

    // R1 address readback
    set_addr(24'h89_67_45);
    bus_rd(3'd2, v); chk("R1 addr lo", v, 8'h45);
    bus_rd(3'd3, v); chk("R1 addr mid", v, 8'h67);
    bus_rd(3'd4, v); chk("R1 addr hi", v, 8'h89);

    // R4 single-byte commands
    push_len("R4 len", 1); push_b("R4", 8'h06);
    bus_wr(3'd1, 8'h06);
    bus_rd(3'd1, v); chk("R11 busy after cmd", v[0], 1'b1);
    wait_stat(0, 1'b0);
    chk("R11 cs released", cs_n, 1'b1);
    push_len("R4 len", 1); push_b("R4", 8'hC7);
    bus_wr(3'd1, 8'hC7); wait_stat(0, 1'b0);
    push_len("R4 undefined len", 1); push_b("R4", 8'h9F);
    bus_wr(3'd1, 8'h9F); wait_stat(0, 1'b0);

    // R5 write status
    bus_wr(3'd0, 8'h55);
    push_len("R5 len", 2); push_b("R5", 8'h01); push_b("R5", 8'h55);
    bus_wr(3'd1, 8'h01); wait_stat(0, 1'b0);

    // R6 sector erase, R12 command while busy ignored
    set_addr(24'hEF_CD_AB);
    push_len("R6 len", 4);
    push_b("R6", 8'hD8); push_b("R6", 8'hEF); push_b("R6", 8'hCD); push_b("R6", 8'hAB);
    bus_wr(3'd1, 8'hD8);
    repeat (5) @(negedge clk);
    bus_wr(3'd1, 8'h06);
    wait_stat(0, 1'b0);

    // R12 no-op while idle
    bus_wr(3'd1, 8'hFF);
    repeat (40) @(negedge clk);
    chk("R12 idle noop cs", cs_n, 1'b1);
    bus_rd(3'd1, v); chk("R12 idle noop status", v, 8'h02);

    // R7 page program stream
    set_addr(24'h12_34_56);
    push_len("R7 len", 4 + 5);
    push_b("R7", 8'h02); push_b("R7", 8'h12); push_b("R7", 8'h34); push_b("R7", 8'h56);
    bus_wr(3'd1, 8'h02);
    for (int i = 0; i < 5; i++) begin
      wait_stat(3, 1'b1);
      chk("R7 cs held", cs_n, 1'b0);
      push_b("R7", 8'(8'hA5 + i * 17));
      bus_wr(3'd0, 8'(8'hA5 + i * 17));
      bus_rd(3'd1, v);
      chk("R7 wreq cleared", v[3], 1'b0);
      chk("R2 txe low while shifting", v[1], 1'b0);
    end
    bus_wr(3'd1, 8'hFF);
    wait_stat(0, 1'b0);
    chk("R7 cs released after noop", cs_n, 1'b1);

    // R10 read status and signature
    push_len("R10 len", 2); push_b("R10", 8'h05); push_b("R10", 8'h00);
    bus_wr(3'd1, 8'h05);
    wait_stat(2, 1'b1);
    bus_rd(3'd0, v); chk("R10 status byte", v, resp(1));
    bus_rd(3'd1, v); chk("R11 rxr cleared", v[2], 1'b0);
    push_len("R10 len", 5); push_b("R10", 8'hAB);
    for (int i = 0; i < 4; i++) push_b("R10 dummy", 8'h00);
    bus_wr(3'd1, 8'hAB);
    wait_stat(2, 1'b1);
    bus_rd(3'd0, v); chk("R10 signature", v, resp(4));
    wait_stat(0, 1'b0);

    // R8 continuous read, R9 fast read
    stream_read("R8", 8'h03, 1'b0, 4);
    stream_read("R9", 8'h0B, 1'b1, 3);

    repeat (20) @(negedge clk);
    chk("R3 scoreboard bytes drained", exp_b_q.size(), 0);
    chk("R3 scoreboard frames drained", exp_l_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule